// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block sits in front of a small microcontroller's interrupt controller and turns raw external pins into sticky request flags. Every pin is first registered through a short metastability chain. Each source then has its own edge rule. Two vectored inputs trigger on an edge that software selects. A third vectored input triggers on any change. A quasi-interrupt input triggers on a rising edge, and a bank of key-scan inputs triggers on falling edges. The quasi-interrupt input and the key-scan bank share one flag.

A vectored source raises its vector request while both its flag and its enable bit are 1. The quasi flag never raises a vector: software polls it, or it ends a power-down state through the wake output. The wake output is built from register outputs with gates only, so it keeps working while the CPU clock is stopped. Software uses a small register port to read flags, clear them by writing 0, write the enable bits and choose the trigger edges. Arbitration between vectors is handled downstream.

Top module: `xirq_edge_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, every flag, enable bit and edge-select bit is 0. vec_req_o, wake_o and the read data are then 0.
- R2: Source ext1 (flag bit 1) sets its flag on the edge chosen by select bit 1 (0 = rising, 1 = falling). A pin change captured at clock edge k shows in the flag after clock edge k+2.
- R3: Source ext0 (flag bit 0) has one more synchroniser stage than the other inputs. It sets its flag on the edge chosen by select bit 0 (0 = rising, 1 = falling), and a change captured at edge k shows after edge k+3.
- R4: Source ext_both (flag bit 2) sets its flag on both rising and falling edges of its pin, with the same latency as R2.
- R5: The quasi flag (bit 3) is set by a rising edge on quasi_i or by a falling edge on any keys_i bit, with the same latency as R2. It drives no vector request.
- R6: vec_req_o[i] for i = 0..2 is 1 exactly while flag bit i and enable bit i are both 1.
- R7: Flags are sticky. A write to address 0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A new edge in the clearing cycle leaves the flag set.
- R8: Changing an edge-select bit while the pin is steady does not set a flag.
- R9: wake_o is 1 when any vectored flag is set together with its enable bit, or when the quasi flag is set, regardless of enable bit 3.
- R10: Register map: address 0 holds the flags and address 1 the enable bits, both with bit positions as in R2 to R5. Address 2 holds the edge selects in bits 1:0 with upper bits reading 0. Address 3 reads 0. Reads are combinational from reg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext0_i | input | 1 | Vectored input with selectable edge and extra sync stage |
| ext1_i | input | 1 | Vectored input with selectable edge |
| ext_both_i | input | 1 | Vectored input triggered by either edge |
| quasi_i | input | 1 | Quasi-interrupt input, rising edge |
| keys_i | input | 8 | Key-scan inputs, falling edge, shared with quasi flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| vec_req_o | output | 3 | Vector requests for ext0, ext1, ext_both |
| wake_o | output | 1 | Power-down termination request |

## Verification
A corrupted flag or enable bit shows at vec_req_o and wake_o in the same cycle it appears, and at reg_rdata_o as soon as address 0 or 1 is selected. Comparing every clock therefore catches it within one cycle. A wrong synchroniser depth or a wrong edge polarity does not show as a bad value. It shows as a flag that rises one cycle early or late, or not at all, so the model tracks the exact capture cycle of every pin change. A clear that loses a simultaneous edge shows as a flag at 0 on the cycle after the write, where the model expects 1.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NUM_SRC  = 4;  // ext0, ext1, ext_both, quasi
  localparam int NUM_VEC  = 3;
  localparam int NUM_SEL  = 2;
  localparam int ADDR_W   = 2;

  localparam int SRC_EXT0 = 0;
  localparam int SRC_EXT1 = 1;
  localparam int SRC_BOTH = 2;
  localparam int SRC_QSI  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_SEL  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prv_o
);
  // stage STAGES-1 is the synchronised level, stage STAGES the previous one
  logic [STAGES:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], pin_i};
  end

  assign lvl_o = chain_q[STAGES-1];
  assign prv_o = chain_q[STAGES];
endmodule

// File: rtl/xirq_flag_regs.sv
module xirq_flag_regs
  import xirq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int NSEL = NUM_SEL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   edge_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   flag_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSEL-1:0]   sel_o,
  output logic [NSRC-1:0]   rdata_o
);
  logic [NSRC-1:0] flag_q, en_q;
  logic [NSEL-1:0] sel_q;
  logic            wr_flag, wr_en, wr_sel;

  assign wr_flag = we_i && (addr_i == ADDR_FLAG);
  assign wr_en   = we_i && (addr_i == ADDR_EN);
  assign wr_sel  = we_i && (addr_i == ADDR_SEL);

  // edge in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (wr_flag ? (flag_q & wdata_i) : flag_q) | edge_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      if (wr_en)  en_q  <= wdata_i;
      if (wr_sel) sel_q <= wdata_i[NSEL-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      ADDR_FLAG: rdata_o = flag_q;
      ADDR_EN:   rdata_o = en_q;
      ADDR_SEL:  rdata_o = NSRC'(sel_q);
      default:   rdata_o = '0;
    endcase
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit
  import xirq_pkg::*;
#(
  parameter int NUM_KEYS  = 8,
  parameter int IN_STAGES = 2,
  parameter int EXT0_XTRA = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext0_i,
  input  logic                ext1_i,
  input  logic                ext_both_i,
  input  logic                quasi_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [NUM_SRC-1:0]  reg_wdata_i,
  output logic [NUM_SRC-1:0]  reg_rdata_o,
  output logic [NUM_VEC-1:0]  vec_req_o,
  output logic                wake_o
);
  localparam int EXT0_STAGES = IN_STAGES + EXT0_XTRA;
  localparam int MISC_W      = 3;

  logic                lvl0, prv0;
  logic [MISC_W-1:0]   lvl_m, prv_m;
  logic [NUM_KEYS-1:0] lvl_k, prv_k;
  logic [NUM_SRC-1:0]  edge_d, flag_q, en_q;
  logic [NUM_SEL-1:0]  sel_q;

  xirq_sync #(.WIDTH(1), .STAGES(EXT0_STAGES)) u_sync_ext0 (
    .clk_i, .rst_ni, .pin_i(ext0_i), .lvl_o(lvl0), .prv_o(prv0)
  );

  xirq_sync #(.WIDTH(MISC_W), .STAGES(IN_STAGES)) u_sync_misc (
    .clk_i, .rst_ni, .pin_i({quasi_i, ext_both_i, ext1_i}),
    .lvl_o(lvl_m), .prv_o(prv_m)
  );

  xirq_sync #(.WIDTH(NUM_KEYS), .STAGES(IN_STAGES)) u_sync_keys (
    .clk_i, .rst_ni, .pin_i(keys_i), .lvl_o(lvl_k), .prv_o(prv_k)
  );

  // level compare: a select change alone never forms an edge
  always_comb begin
    edge_d[SRC_EXT0] = sel_q[0] ? (prv0 & ~lvl0) : (lvl0 & ~prv0);
    edge_d[SRC_EXT1] = sel_q[1] ? (prv_m[0] & ~lvl_m[0]) : (lvl_m[0] & ~prv_m[0]);
    edge_d[SRC_BOTH] = lvl_m[1] ^ prv_m[1];
    edge_d[SRC_QSI]  = (lvl_m[2] & ~prv_m[2]) | (|(prv_k & ~lvl_k));
  end

  xirq_flag_regs #(.NSRC(NUM_SRC), .NSEL(NUM_SEL)) u_regs (
    .clk_i, .rst_ni,
    .edge_i (edge_d),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .flag_o (flag_q),
    .en_o   (en_q),
    .sel_o  (sel_q),
    .rdata_o(reg_rdata_o)
  );

  assign vec_req_o = flag_q[NUM_VEC-1:0] & en_q[NUM_VEC-1:0];
  assign wake_o    = (|vec_req_o) | (|flag_q[NUM_SRC-1:NUM_VEC]);
endmodule

// File: rtl/xirq_edge_unit_chk.sv
module xirq_edge_unit_chk
  import xirq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] flag_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] edge_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [NUM_VEC-1:0] vec_req_o,
  input logic               wake_o
);
  assert_quasi_wakes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i[SRC_QSI] |-> wake_o);

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    assert_vec_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[i] |-> !vec_req_o[i]);
    assert_vec_wakes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && en_i[i]) |-> wake_o);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && !(reg_we_i && reg_addr_i == 2'd0 && !reg_wdata_i[i])) |=> flag_i[i]);
    assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == 2'd0 && !reg_wdata_i[i] && !edge_i[i]) |=> !flag_i[i]);
    assert_edge_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_i[i] |=> flag_i[i]);
  end
endmodule

bind xirq_edge_unit xirq_edge_unit_chk u_chk (
  .clk_i, .rst_ni,
  .flag_i(flag_q), .en_i(en_q), .edge_i(edge_d),
  .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .vec_req_o, .wake_o
);

// File: tb/xirq_edge_unit_tb.sv
`timescale 1ns/1ps
module xirq_edge_unit_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ext0 = 0, ext1 = 0, both = 0, quasi = 0;
  logic [7:0] keys = 8'hFF;
  logic       we = 0;
  logic [1:0] addr = 0;
  logic [3:0] wdata = 0;
  logic [3:0] rdata;
  logic [2:0] vec;
  logic       wake;

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  xirq_edge_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ext0_i(ext0), .ext1_i(ext1), .ext_both_i(both), .quasi_i(quasi), .keys_i(keys),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .vec_req_o(vec), .wake_o(wake)
  );

  // behavioural reference: pin history queue, index 0 = newest sample
  logic [11:0] hist[$];
  logic [3:0]  m_flag, m_en;
  logic [1:0]  m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{12'h0, 12'h0, 12'h0, 12'h0};
      m_flag = 0; m_en = 0; m_sel = 0;
    end else begin
      logic [3:0] e;
      logic r0, f0, r1, f1;
      r0 = hist[2][0] && !hist[3][0];  f0 = !hist[2][0] && hist[3][0];
      r1 = hist[1][1] && !hist[2][1];  f1 = !hist[1][1] && hist[2][1];
      e[0] = m_sel[0] ? f0 : r0;
      e[1] = m_sel[1] ? f1 : r1;
      e[2] = hist[1][2] != hist[2][2];
      e[3] = (hist[1][3] && !hist[2][3]) || ((~hist[1][11:4] & hist[2][11:4]) != 0);
      if (we) begin
        case (addr)
          2'd0: m_flag = m_flag & wdata;
          2'd1: m_en = wdata;
          2'd2: m_sel = wdata[1:0];
          default: ;
        endcase
      end
      m_flag = m_flag | e;
      hist.push_front({keys, quasi, both, ext1, ext0});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    #1;
    if (!done) begin
      logic [2:0] x_vec;
      logic       x_wake;
      logic [3:0] x_rd;
      x_vec  = m_flag[2:0] & m_en[2:0];
      x_wake = (x_vec != 0) || m_flag[3];
      case (addr)
        2'd0: x_rd = m_flag;
        2'd1: x_rd = m_en;
        2'd2: x_rd = {2'b00, m_sel};
        default: x_rd = 4'h0;
      endcase
      n_vec++;
      if (vec !== x_vec) begin
        n_bad++; $display("FAIL %s vec_req_o actual=%b expected=%b t=%0t", cur_req, vec, x_vec, $time);
      end
      n_vec++;
      if (wake !== x_wake) begin
        n_bad++; $display("FAIL %s wake_o actual=%b expected=%b t=%0t", cur_req, wake, x_wake, $time);
      end
      n_vec++;
      if (rdata !== x_rd) begin
        n_bad++; $display("FAIL %s reg_rdata_o addr=%0d actual=%h expected=%h t=%0t", cur_req, addr, rdata, x_rd, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); addr = a;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 10);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    tick(3); rst_n = 1;
    rd(0); rd(1); rd(2); rd(3); tick(2);

    cur_req = "R10";
    wr(1, 4'b1010); rd(1); rd(2); rd(3); wr(2, 4'b1111); rd(2); wr(2, 4'b0000); rd(0);

    cur_req = "R2";
    wr(1, 4'b0111);
    @(negedge clk) ext1 = 1; tick(5);
    wr(0, 4'b1101); wr(2, 4'b0010); tick(2);
    @(negedge clk) ext1 = 0; tick(5);

    cur_req = "R3";
    wr(0, 4'b0000);
    @(negedge clk) ext0 = 1; tick(6);
    wr(0, 4'b1110); wr(2, 4'b0001);
    @(negedge clk) ext0 = 0; tick(6);

    cur_req = "R4";
    wr(0, 4'b0000);
    @(negedge clk) both = 1; tick(4); wr(0, 4'b1011);
    @(negedge clk) both = 0; tick(4);

    cur_req = "R5";
    wr(0, 4'b0000); wr(1, 4'b0000);
    @(negedge clk) quasi = 1; tick(4); wr(0, 4'b0111);
    @(negedge clk) keys[5] = 0; tick(4); wr(0, 4'b0000);
    @(negedge clk) keys[5] = 1; tick(4);
    @(negedge clk) quasi = 0; tick(4);

    cur_req = "R6";
    wr(1, 4'b0101);
    @(negedge clk) begin both = 1; ext1 = 1; end tick(5);
    wr(1, 4'b0010); tick(2); wr(1, 4'b0111); tick(2);

    cur_req = "R7";
    for (int off = 0; off < 5; off++) begin
      wr(0, 4'b0000); tick(1);
      @(negedge clk) both = ~both;
      tick(off);
      wr(0, 4'b1011); tick(3);
    end
    wr(0, 4'b1111); rd(0); tick(2);

    cur_req = "R8";
    wr(0, 4'b0000); wr(2, 4'b0000);
    @(negedge clk) begin ext0 = 1; ext1 = 1; end tick(6);
    wr(0, 4'b0000); rd(0);
    for (int k = 0; k < 4; k++) begin
      wr(2, k[1:0] ^ 2'b11); tick(3);
    end
    rd(0); tick(2);

    cur_req = "R9";
    wr(1, 4'b1111);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      case ($urandom_range(0, 9))
        0: ext0 = ~ext0;
        1: ext1 = ~ext1;
        2: both = ~both;
        3: quasi = ~quasi;
        4: keys[$urandom_range(0, 7)] ^= 1'b1;
        default: ;
      endcase
      we = ($urandom_range(0, 5) == 0);
      addr = 2'($urandom_range(0, 3));
      wdata = 4'($urandom_range(0, 15));
    end
    @(negedge clk) we = 0;
    tick(4);
    finish_run();
  end
endmodule